// File: doc/BRIEF.md
# Parameterized Hamming Single-Error-Correcting Encoder

This block turns a K-bit data word into a Hamming code word that can correct one flipped bit. Code positions are numbered from 1. Each check bit sits at a position that is a power of two (1, 2, 4, 8, ...). The data bits fill the remaining positions, lowest data bit first. The number of check bits R is worked out from K during elaboration, so one source covers every word width from 1 to 26 bits without hand-written parity equations.

A producer presents a word together with a valid strobe. One clock later the code word appears on the output, and an output valid flag is high for exactly that cycle. In a cycle with no valid input, the output word keeps its last value. An active-low asynchronous reset clears both outputs.

Top module: `hamSecEncoder`

## Requirements
- R1: The code word is K+R bits wide, where R is the smallest integer with 2^R >= K+R+1. For example, K=5 gives a 9-bit word and K=26 gives a 31-bit word.
- R2: Code position p (counted from 1) drives output bit p-1. The data bits, with input bit 0 first, occupy the positions that are not powers of two, in rising order.
- R3: The check bit at position 2^j equals the XOR of all data positions whose index has bit j set. As a result, every emitted word has a zero syndrome, where the syndrome is the XOR of the indices of all positions holding a 1.
- R4: With K=5 and input 5'b10101 (P1 is bit 0), the output word is 9'h1AC. In position order 1..9 this is 0,0,1,1,0,1,0,1,1.
- R5: The output valid flag is high in the cycle after a clock edge that samples input valid high, and low after an edge that samples it low.
- R6: The output word changes to the encoding of the sampled input one clock after the input is accepted, including when valid words arrive back to back.
- R7: When input valid is low at a clock edge, the output word keeps its previous value, whatever the data input carries.
- R8: While reset is low, the output valid flag and the output word are 0. Reset takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Data word valid strobe |
| inData | input | K | Data word; bit 0 is the first data bit |
| outValid | output | 1 | Code word valid, one cycle after an accepted input |
| outCode | output | K+R | Code word; bit p-1 holds position p |

## Verification
Two functions can land in the same cycle. One is loading a fresh word, which happens on back-to-back valid strobes. The other is either holding the old word or the output valid flag falling as a gap begins. The bench drives streams of consecutive valid words, then single-cycle gaps, then long idle runs with the data input still changing. Every cycle, it compares the output word and the flag against a reference model that tracks what should be held and what should be reloaded. It also pulses reset between clock edges to confirm that the clear does not wait for a clock.

// File: rtl/hamPkg.sv
package hamPkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;
  } encStrobe_t;

  // Smallest r with 2^r >= k + r + 1
  function automatic int checkBits(input int k);
    int r;
    r = 0;
    while ((1 << r) < (k + r + 1)) r++;
    return r;
  endfunction

  // Zero-based data bit index carried at code position p (p not a power of two)
  function automatic int dataSlot(input int p);
    return p - $clog2(p + 1) - 1;
  endfunction

  // Positions (as bit p-1) whose index has bit j set
  function automatic logic [63:0] coverMask(input int n, input int j);
    logic [63:0] m;
    m = '0;
    for (int p = 1; p <= n; p++)
      if (((p >> j) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/hamEncCtrl.sv
module hamEncCtrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output hamPkg::encStrobe_t strobe,
  output logic               outValid
);

  always_comb begin
    strobe.load = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/hamEncPath.sv
module hamEncPath #(
  parameter int K = 8,
  localparam int R = hamPkg::checkBits(K),
  localparam int N = K + R
) (
  input  logic               clk,
  input  logic               rstN,
  input  hamPkg::encStrobe_t strobe,
  input  logic [K-1:0]       inData,
  output logic [N-1:0]       outCode
);

  logic [N-1:0] spread;
  logic [R-1:0] parity;
  logic [N-1:0] codeNext;

  // Scatter data into non-power-of-two positions
  for (genvar p = 1; p <= N; p++) begin : gSpread
    if ((p & (p - 1)) != 0) begin : gData
      localparam int SLOT = hamPkg::dataSlot(p);
      assign spread[p-1] = inData[SLOT];
    end else begin : gHole
      assign spread[p-1] = 1'b0;
    end
  end

  // One reduction tree per check bit
  for (genvar j = 0; j < R; j++) begin : gParity
    localparam logic [63:0] MASK = hamPkg::coverMask(N, j);
    assign parity[j] = ^(spread & MASK[N-1:0]);
  end

  // Merge check bits into their positions
  for (genvar p = 1; p <= N; p++) begin : gMerge
    if ((p & (p - 1)) == 0) begin : gCheck
      assign codeNext[p-1] = parity[$clog2(p)];
    end else begin : gPass
      assign codeNext[p-1] = spread[p-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outCode <= '0;
    else if (strobe.load) outCode <= codeNext;
  end

endmodule

// File: rtl/hamSecEncoder.sv
module hamSecEncoder #(
  parameter int K = 8,
  localparam int R = hamPkg::checkBits(K),
  localparam int N = K + R
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [K-1:0] inData,
  output logic         outValid,
  output logic [N-1:0] outCode
);

  hamPkg::encStrobe_t strobe;

  hamEncCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hamEncPath #(.K(K)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inData  (inData),
    .outCode (outCode)
  );

endmodule

// File: rtl/hamSecEncoderChecker.sv
module hamSecEncoderChecker #(
  parameter int K = 8,
  parameter int N = 12
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [K-1:0] inData,
  input logic         outValid,
  input logic [N-1:0] outCode
);

  logic [7:0]   syndrome;
  logic [K-1:0] gathered;

  always_comb begin
    int j;
    syndrome = '0;
    gathered = '0;
    j = 0;
    for (int p = 1; p <= N; p++) begin
      if (outCode[p-1]) syndrome = syndrome ^ 8'(p);
      if ((p & (p - 1)) != 0) begin
        gathered[j] = outCode[p-1];
        j++;
      end
    end
  end

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R5
  AST_VALID_LOW_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outCode)); // R7
  AST_DATA_PLACED: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (gathered == $past(inData))); // R2
  AST_ZERO_SYNDROME: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (syndrome == 8'd0)); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |-> (!outValid && outCode == '0)); // R8

endmodule

bind hamSecEncoder hamSecEncoderChecker #(.K(K), .N(N)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inData   (inData),
  .outValid (outValid),
  .outCode  (outCode)
);

// File: tb/sim_hamSecEncoder.sv
`timescale 1ns/1ps
module sim_hamSecEncoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [4:0]  dataA = '0;
  logic [25:0] dataB = '0;
  logic        validA, validB;
  logic [8:0]  codeA;
  logic [30:0] codeB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] expA = '0, expB = '0;
  logic        expValid = 1'b0;

  always #5 clk = ~clk;

  hamSecEncoder #(.K(5)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(dataA),
    .outValid(validA), .outCode(codeA));

  hamSecEncoder #(.K(26)) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(dataB),
    .outValid(validB), .outCode(codeB));

  // Behavioural reference: fill a position array, then patch in check bits
  function automatic logic [63:0] refEncode(input int k, input logic [63:0] d);
    bit pos[$];
    int n, r, j;
    logic [63:0] res;
    r = 0;
    while ((1 << r) < (k + r + 1)) r++;
    n = k + r;
    pos.push_back(1'b0);
    j = 0;
    for (int p = 1; p <= n; p++) begin
      if ((p & (p - 1)) == 0) pos.push_back(1'b0);
      else begin pos.push_back(d[j]); j++; end
    end
    for (int b = 1; b <= n; b = b * 2) begin
      bit acc;
      acc = 0;
      for (int p = 1; p <= n; p++) if ((p & b) != 0) acc ^= pos[p];
      pos[b] = acc;
    end
    res = '0;
    for (int p = 1; p <= n; p++) res[p-1] = pos[p];
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    check(validA == expValid, {tag, " R5 validA"}, 64'(validA), 64'(expValid));
    check(validB == expValid, {tag, " R5 validB"}, 64'(validB), 64'(expValid));
    check(codeA == expA[8:0], {tag, " R2 R3 R6 R7 codeA"}, 64'(codeA), 64'(expA[8:0]));
    check(codeB == expB[30:0], {tag, " R2 R3 R6 R7 codeB"}, 64'(codeB), 64'(expB[30:0]));
  endtask

  // One cycle: apply inputs, model the edge, compare away from it
  task automatic step(input bit v, input logic [4:0] a, input logic [25:0] b, input string tag);
    inValid = v; dataA = a; dataB = b;
    @(posedge clk);
    if (!rstN) begin
      expValid = 0; expA = '0; expB = '0;
    end else begin
      expValid = v;
      if (v) begin
        expA = refEncode(5, 64'(a));
        expB = refEncode(26, 64'(b));
      end
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    // R8: reset state
    @(negedge clk);
    step(1'b1, 5'h1f, 26'h3ffffff, "reset R8");
    step(1'b0, 5'h00, 26'h0, "reset R8");
    // R1: widths
    check($bits(codeA) == 9, "R1 width K=5", 64'($bits(codeA)), 64'd9);
    check($bits(codeB) == 31, "R1 width K=26", 64'($bits(codeB)), 64'd31);
    rstN = 1'b1;
    step(1'b0, 5'h0a, 26'h123, "idle after reset R7");
    // R4: worked example
    step(1'b1, 5'b10101, 26'h0, "example R4");
    check(codeA == 9'h1ac, "R4 example code", 64'(codeA), 64'h1ac);
    // R7: hold with changing data
    for (int i = 0; i < 4; i++) step(1'b0, 5'(i * 7), 26'(i * 911), "hold R7");
    check(codeA == 9'h1ac, "R7 hold example", 64'(codeA), 64'h1ac);
    // R2: walking one across data bits
    for (int i = 0; i < 26; i++) step(1'b1, 5'(1 << (i % 5)), 26'(1) << i, "walk R2");
    // Boundary words
    step(1'b1, 5'h1f, 26'h3ffffff, "all ones R3");
    step(1'b1, 5'h00, 26'h0, "all zeros R3");
    step(1'b0, 5'h1f, 26'h3ffffff, "gap R5");
    // R6: back-to-back and gaps mixed
    for (int i = 0; i < 300; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, 5'($urandom), 26'($urandom), "stream R6");
    end
    // R8: reset between edges clears immediately
    step(1'b1, 5'h15, 26'h2aaaaaa, "pre-reset R6");
    #2 rstN = 1'b0;
    #1;
    check(validA == 1'b0 && validB == 1'b0, "R8 async valid", 64'({validA, validB}), 64'd0);
    check(codeA == '0 && codeB == '0, "R8 async code", 64'(codeA) | 64'(codeB), 64'd0);
    @(negedge clk);
    expValid = 0; expA = '0; expB = '0;
    step(1'b1, 5'h07, 26'h7, "in reset R8");
    rstN = 1'b1;
    step(1'b1, 5'h07, 26'h7, "after reset R6");
    step(1'b0, 5'h00, 26'h0, "final R5");
    summary();
  end

endmodule